// File: doc/BRIEF.md
# Serial ADC Result Frame Reader

This block is the host side of a three-wire link (chip select, serial clock, serial data in) to a delta-sigma converter. A `start` pulse makes it pull chip select low. It then keeps the serial clock low and watches the data line. The converter holds that line high while a conversion is still running. Once the line reads low, the reader issues 32 clock pulses and samples one bit on each rising edge, most significant bit first. It releases chip select one half-period after the last falling edge.

The captured word is split into four parts: a busy flag, a dummy bit that must read zero, a combined sign/MSB pair, and a 24-bit result followed by five sub-LSB bits. The pair decides the range. `11` means the input is above full scale and `00` means it is below full scale; the other two patterns are in-range values. The reader returns the result sign-extended to a wider word, saturating it when the input is out of range. It also returns the sub-LSB bits, range flags, a frame-error flag and a validity flag. If the busy flag never clears, a poll limit gives up on the read and reports a timeout.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset: `cs_n`=1, `sck`=0, `done`=0, every flag 0 and `result`=0.
- R2: After `start` in idle, `cs_n` goes low while `sck` stays low. Shifting begins only after `sdo` has been sampled low.
- R3: A frame has exactly 32 `sck` pulses. Each high and each low phase lasts `half_div`+1 clocks. If `sdo` is first seen low on the B-th poll clock (B busy clocks before it), `cs_n` stays low for B+1+65·(`half_div`+1) clocks in total.
- R4: `sdo` is sampled at each rising `sck` edge, first bit = frame bit 31. For in-range frames, `result` is frame bits 28..5 read as a two's-complement value and sign-extended to OUT_W. `sub_lsb` is frame bits 4..0.
- R5: If frame bits 29,28 = 11, then `overrange`=1 and `result` = +(2^23−1) sign-extended.
- R6: If frame bits 29,28 = 00, then `underrange`=1 and `result` = −2^23 sign-extended.
- R7: If frame bit 30 (dummy) is 1, then `frame_err`=1. The result is still decoded.
- R8: If `sdo` stays high for POLL_MAX poll clocks, the reader raises `cs_n` after exactly POLL_MAX low clocks, sets `timeout`=1 and clears the range and valid flags. The next completed frame clears `timeout`.
- R9: `done` is a one-clock pulse. It arrives the clock after `cs_n` rises, together with the new fields. The fields then hold their values until the next `done`.
- R10: `start` has no effect while a read is in progress, and `sdo` activity while `cs_n` is high causes no read and no `done`.
- R11: `valid`=1 only for a completed frame that has the dummy bit clear and lies in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a read (accepted in idle only) |
| half_div | input | DIV_W | SCK half-period minus one, in system clocks |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| result | output | OUT_W | Signed, saturated conversion result |
| sub_lsb | output | SUB_W | Bits below the result LSB |
| overrange | output | 1 | Input above positive full scale |
| underrange | output | 1 | Input below negative full scale |
| frame_err | output | 1 | Dummy bit read high |
| valid | output | 1 | Frame good and in range |
| timeout | output | 1 | Poll limit reached |
| done | output | 1 | One-clock completion strobe |

## Verification
Let H be `half_div`+1 and B the number of clocks the converter model holds the data line busy. The frame fields and `done` are due one clock after chip select rises. Chip select rises B+1+65·H clocks after `start`, or POLL_MAX clocks after `start` when the poll times out. Rather than assume a fixed latency for `done`, the bench counts low chip-select clocks, rising SCK edges and SCK-high clocks at the falling system-clock edge, and compares those counts with the closed-form values. It then checks the fields on the falling edge where `done` is seen, confirms that `done` is low one clock later, and checks the fields again after several idle clocks.

// File: rtl/adc_frame_pkg.sv
// Package: shared state encoding for the serial ADC frame reader.
// Assumes: the frame is status(3) + result + sub-LSB bits.
package adc_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } rd_state_t;

    typedef struct packed {
        logic over;
        logic under;
        logic ferr;
        logic valid;
    } range_flags_t;
endpackage

// File: rtl/sck_tick_gen.sv
// Module: sck_tick_gen
// Emits one tick every half_div+1 clocks while run is high. The count
// restarts from zero whenever run is low.
// Assumes: half_div is held constant while run is high.
module sck_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_div);

    // Phase counter: counts clocks within the current SCK half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R3: the phase counter never passes the programmed half-period.
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= half_div));
endmodule

// File: rtl/frame_shift_ctrl.sv
// Module: frame_shift_ctrl
// Sequencer: asserts chip select, polls the busy flag on sdo, shifts in
// FRAME_W bits on the rising SCK edges, then holds SCK low for one
// half-period before releasing chip select.
// Assumes: sdo is already synchronous to clk.
module frame_shift_ctrl
    import adc_frame_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int DIV_W    = 8,
    parameter int POLL_MAX = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DIV_W-1:0]   half_div,
    input  logic               sdo,
    input  logic               tick,
    output logic               run,
    output logic [DIV_W-1:0]   div_q,
    output logic               cs_n,
    output logic               sck,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_done,
    output logic               poll_to
);
    localparam int BIT_W  = $clog2(FRAME_W + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    rd_state_t         st_q;
    logic [BIT_W-1:0]  bitcnt_q;
    logic [POLL_W-1:0] poll_q;

    assign run = (st_q == ST_SHIFT) || (st_q == ST_TAIL);

    // Main sequencer: state, chip select, SCK, shift register, poll count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cs_n       <= 1'b1;
            sck        <= 1'b0;
            frame      <= '0;
            bitcnt_q   <= '0;
            poll_q     <= '0;
            div_q      <= '0;
            frame_done <= 1'b0;
            poll_to    <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            poll_to    <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q     <= ST_POLL;
                        cs_n     <= 1'b0;
                        poll_q   <= '0;
                        bitcnt_q <= '0;
                        div_q    <= half_div;
                    end
                end
                ST_POLL: begin
                    if (!sdo) begin
                        st_q <= ST_SHIFT;
                    end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
                        st_q    <= ST_IDLE;
                        cs_n    <= 1'b1;
                        poll_to <= 1'b1;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck      <= 1'b1;
                            frame    <= {frame[FRAME_W-2:0], sdo};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else begin
                            sck <= 1'b0;
                            if (bitcnt_q == BIT_W'(FRAME_W)) st_q <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        st_q       <= ST_IDLE;
                        cs_n       <= 1'b1;
                        frame_done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: SCK stays low while the busy flag is being polled.
    a_r2_sck_idle_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POLL) |-> !sck);
    // R10: SCK only toggles while chip select is asserted.
    a_r10_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    // R3: never more than FRAME_W rising edges in one frame.
    a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= BIT_W'(FRAME_W));
    // R8: the poll count stays below its limit.
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POLL) |-> (poll_q < POLL_W'(POLL_MAX)));
endmodule

// File: rtl/frame_field_decode.sv
// Module: frame_field_decode
// Pure decode of a captured frame. It produces the saturated, sign-extended
// result, the sub-LSB field and the range/error flags.
// Assumes: FRAME_W == RES_W + SUB_W + 3 and OUT_W > RES_W.
module frame_field_decode
    import adc_frame_pkg::*;
#(
    parameter int RES_W = 24,
    parameter int SUB_W = 5,
    parameter int OUT_W = 32,
    localparam int FRAME_W = RES_W + SUB_W + 3
) (
    input  logic [FRAME_W-1:0] frame,
    output logic [OUT_W-1:0]   result,
    output logic [SUB_W-1:0]   sub_lsb,
    output range_flags_t       flags
);
    localparam int MSB_POS = SUB_W + RES_W - 1;
    localparam int SIG_POS = MSB_POS + 1;
    localparam int DMY_POS = SIG_POS + 1;

    logic [RES_W-1:0] code;
    logic             sig, msb, dmy;

    assign code    = frame[MSB_POS:SUB_W];
    assign sub_lsb = frame[SUB_W-1:0];
    assign sig     = frame[SIG_POS];
    assign msb     = frame[MSB_POS];
    assign dmy     = frame[DMY_POS];

    // Range decode and saturation of the result word.
    always_comb begin
        flags.over  = sig & msb;
        flags.under = ~sig & ~msb;
        flags.ferr  = dmy;
        flags.valid = ~dmy & (sig ^ msb);
        if (flags.over)
            result = OUT_W'(signed'({1'b0, {(RES_W-1){1'b1}}}));
        else if (flags.under)
            result = OUT_W'(signed'({1'b1, {(RES_W-1){1'b0}}}));
        else
            result = OUT_W'(signed'(code));
    end
endmodule

// File: rtl/adc_frame_reader.sv
// Module: adc_frame_reader (top)
// Host-side reader for a 32-bit converter result frame. It connects the
// tick generator, the sequencer and the decoder, and registers the decoded
// fields together with the done strobe.
// Assumes: sdo is synchronous to clk; half_div is stable while start is high.
module adc_frame_reader
    import adc_frame_pkg::*;
#(
    parameter int RES_W    = 24,
    parameter int SUB_W    = 5,
    parameter int OUT_W    = 32,
    parameter int DIV_W    = 8,
    parameter int POLL_MAX = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             sdo,
    output logic             cs_n,
    output logic             sck,
    output logic [OUT_W-1:0] result,
    output logic [SUB_W-1:0] sub_lsb,
    output logic             overrange,
    output logic             underrange,
    output logic             frame_err,
    output logic             valid,
    output logic             timeout,
    output logic             done
);
    localparam int FRAME_W = RES_W + SUB_W + 3;

    logic               tick, run, frame_done, poll_to;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] frame;
    logic [OUT_W-1:0]   dec_result;
    logic [SUB_W-1:0]   dec_sub;
    range_flags_t       dec_flags;

    sck_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .half_div(div_q), .tick(tick)
    );

    frame_shift_ctrl #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .POLL_MAX(POLL_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .sdo(sdo), .tick(tick), .run(run), .div_q(div_q),
        .cs_n(cs_n), .sck(sck), .frame(frame),
        .frame_done(frame_done), .poll_to(poll_to)
    );

    frame_field_decode #(.RES_W(RES_W), .SUB_W(SUB_W), .OUT_W(OUT_W)) u_dec (
        .frame(frame), .result(dec_result), .sub_lsb(dec_sub), .flags(dec_flags)
    );

    // Output registers: load on frame completion or timeout, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            sub_lsb    <= '0;
            overrange  <= 1'b0;
            underrange <= 1'b0;
            frame_err  <= 1'b0;
            valid      <= 1'b0;
            timeout    <= 1'b0;
            done       <= 1'b0;
        end else if (frame_done) begin
            result     <= dec_result;
            sub_lsb    <= dec_sub;
            overrange  <= dec_flags.over;
            underrange <= dec_flags.under;
            frame_err  <= dec_flags.ferr;
            valid      <= dec_flags.valid;
            timeout    <= 1'b0;
            done       <= 1'b1;
        end else if (poll_to) begin
            overrange  <= 1'b0;
            underrange <= 1'b0;
            frame_err  <= 1'b0;
            valid      <= 1'b0;
            timeout    <= 1'b1;
            done       <= 1'b1;
        end else begin
            done       <= 1'b0;
        end
    end

    // R9: done lasts one clock.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: fields only change on the clock that raises done.
    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(sub_lsb) && $stable(valid)));
    // R5/R6: over- and underrange are never reported together.
    a_r6_range_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overrange && underrange));
    // R8: a timeout is reported only after chip select is released.
    a_r8_timeout_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> cs_n);
    // R11: a valid frame carries no range or framing error.
    a_r11_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !(overrange || underrange || frame_err || timeout));
endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
    localparam int POLL_MAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half_div = 8'd0;
    logic        sdo;
    logic        cs_n, sck, overrange, underrange, frame_err, valid, timeout, done;
    logic [31:0] result;
    logic [4:0]  sub_lsb;

    int checks = 0;
    int fails  = 0;

    // converter model state
    logic [31:0] frm = '0;
    int          busy_len = 0;
    int          busy_cnt = 0;
    logic [4:0]  idx = 5'd31;
    logic        idle_val = 1'b1;

    // monitor counters
    int cs_cnt = 0, rises = 0, hi_cnt = 0;
    logic sck_prev = 1'b0;

    always #10 clk = ~clk;

    adc_frame_reader #(.POLL_MAX(POLL_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div), .sdo(sdo),
        .cs_n(cs_n), .sck(sck), .result(result), .sub_lsb(sub_lsb),
        .overrange(overrange), .underrange(underrange), .frame_err(frame_err),
        .valid(valid), .timeout(timeout), .done(done)
    );

    assign sdo = cs_n ? idle_val : ((busy_cnt < busy_len) ? 1'b1 : frm[idx]);

    always @(posedge clk) begin
        if (cs_n) busy_cnt <= 0;
        else      busy_cnt <= busy_cnt + 1;
    end

    always @(negedge sck or posedge cs_n) begin
        if (cs_n) idx <= 5'd31;
        else      idx <= idx - 5'd1;
    end

    always @(negedge clk) begin
        if (!cs_n) cs_cnt <= cs_cnt + 1;
        if (sck && !sck_prev) rises <= rises + 1;
        if (sck) hi_cnt <= hi_cnt + 1;
        sck_prev <= sck;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_frame(input int v, input logic dmy, input logic [4:0] sb);
        logic [23:0] c = v[23:0];
        return {1'b0, dmy, (v >= 0), c, sb};
    endfunction

    // Runs one read; returns 1 if done was seen.
    task automatic do_read(input int h, input int busy, input logic [31:0] f,
                           input bit poke, output bit seen);
        frm = f;
        busy_len = busy;
        half_div = 8'(h - 1);
        @(negedge clk);
        cs_cnt = 0; rises = 0; hi_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (poke && i == 20) start = 1'b1;
            if (poke && i == 21) start = 1'b0;
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic run_frame(input string tag, input int h, input int busy,
                             input logic [31:0] f, input logic [31:0] exp_res,
                             input logic ov, input logic un, input logic fe, input bit poke);
        bit seen;
        logic [31:0] r_snap;
        logic exp_valid = !fe && !ov && !un;
        do_read(h, busy, f, poke, seen);
        chk({tag, " R9 done seen"}, seen, 1'b1);
        chk({tag, " R4 result"}, result, exp_res);
        chk({tag, " R4 sub_lsb"}, sub_lsb, f[4:0]);
        chk({tag, " R5 overrange"}, overrange, ov);
        chk({tag, " R6 underrange"}, underrange, un);
        chk({tag, " R7 frame_err"}, frame_err, fe);
        chk({tag, " R11 valid"}, valid, exp_valid);
        chk({tag, " R8 timeout clear"}, timeout, 1'b0);
        chk({tag, " R3 cs low clocks"}, cs_cnt, busy + 1 + 65 * h);
        chk({tag, " R3 sck rises"}, rises, 32);
        chk({tag, " R3 sck high clocks"}, hi_cnt, 32 * h);
        r_snap = result;
        @(negedge clk);
        chk({tag, " R9 done one clock"}, done, 1'b0);
        repeat (4) @(negedge clk);
        chk({tag, " R9 fields held"}, result, r_snap);
        chk({tag, " R10 cs stays high"}, cs_n, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        bit seen;
        int v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", cs_n, 1'b1);
        chk("R1 sck", sck, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 result", result, 32'h0);
        chk("R1 flags", {overrange, underrange, frame_err, valid, timeout}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 poll: sck low while busy
        frm = mk_frame(5, 1'b0, 5'd0);
        busy_len = 10;
        half_div = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 cs low in poll", cs_n, 1'b0);
        chk("R2 sck low in poll", sck, 1'b0);
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);

        // R4 R5 R6 sweep over divider, value magnitude and sign
        for (int h = 1; h <= 3; h++) begin
            for (int k = 0; k < 24; k++) begin
                v = (1 << k) - 1;
                run_frame("R4 pos", h, (k % 4) * 2, mk_frame(v, 1'b0, 5'((k * 7) % 32)),
                          32'(v), 1'b0, 1'b0, 1'b0, 1'b0);
                v = -(1 << k);
                run_frame("R4 neg", h, (k % 3) * 3, mk_frame(v, 1'b0, 5'((k * 11) % 32)),
                          32'(v), 1'b0, 1'b0, 1'b0, 1'b0);
            end
            run_frame("R5 over", h, 1, {4'b0011, 23'h5A5A5, 5'd9},
                      32'h007F_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
            run_frame("R6 under", h, 2, {4'b0000, 23'h12345, 5'd22},
                      32'hFF80_0000, 1'b0, 1'b1, 1'b0, 1'b0);
            run_frame("R7 dummy", h, 0, mk_frame(1000, 1'b1, 5'd3),
                      32'd1000, 1'b0, 1'b0, 1'b1, 1'b0);
        end

        // R10 start while busy is ignored (cs timing unchanged)
        run_frame("R10 start busy", 2, 3, mk_frame(-77, 1'b0, 5'd17),
                  32'(-77), 1'b0, 1'b0, 1'b0, 1'b1);

        // R8 timeout
        do_read(1, 100000, mk_frame(1, 1'b0, 5'd0), 1'b0, seen);
        chk("R8 done on timeout", seen, 1'b1);
        chk("R8 cs low clocks", cs_cnt, POLL_MAX);
        chk("R8 timeout flag", timeout, 1'b1);
        chk("R8 valid cleared", valid, 1'b0);
        chk("R8 no sck", rises, 0);
        @(negedge clk);
        chk("R8 cs released", cs_n, 1'b1);
        run_frame("R8 recover", 1, 0, mk_frame(42, 1'b0, 5'd1),
                  32'd42, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10 sdo activity with cs high: nothing happens
        begin
            bit got_done = 1'b0;
            bit cs_fell = 1'b0;
            for (int i = 0; i < 30; i++) begin
                idle_val = i[0];
                @(negedge clk);
                if (done) got_done = 1'b1;
                if (!cs_n || sck) cs_fell = 1'b1;
            end
            idle_val = 1'b1;
            chk("R10 idle no done", got_done, 1'b0);
            chk("R10 idle no cs/sck", cs_fell, 1'b0);
            chk("R10 idle result held", result, 32'd42);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule